// File: doc/BRIEF.md
# I2C Target Paired-Register Port Expander

This block is the I2C target logic of a 16-pin general-purpose port that is split into two 8-bit halves. A controller on the two-wire bus reaches it at a 7-bit address. The upper four bits of that address are fixed at `0100`, and the lower three come from strap inputs. The block samples SCL and SDA with its own fast system clock through a two-flop synchroniser, and finds START, STOP and the SCL edges in the sampled lines. It answers by asserting an open-drain pull-down enable for SDA.

After the address, a write carries a command byte and then data bytes. The command byte selects one register of four pairs: input, output, polarity inversion and configuration. Data bytes land alternately in the selected register and in its partner of the same pair, and this goes on for as long as the controller sends. A read first writes the command byte, then sends a repeated START and the address with the read bit set. The target then returns the selected register, then its partner, and so on, until the controller declines to acknowledge a byte. Input values are captured when each byte is loaded for transmission, at the SCL fall that ends the preceding acknowledge. A 1 in a polarity bit inverts that input before it is read.

The FSM states are IDLE, ADDR, ADDR_ACK, CMD, CMD_ACK, WDATA, WDATA_ACK, RDATA, RACK and IGNORE. The transitions are as follows. START from any state goes to ADDR, and STOP from any state goes to IDLE. ADDR goes to ADDR_ACK on an address match, otherwise to IGNORE. ADDR_ACK goes to CMD for a write or to RDATA for a read. CMD goes to CMD_ACK, and CMD_ACK goes to WDATA. WDATA goes to WDATA_ACK, which returns to WDATA. RDATA goes to RACK after eight bits. RACK goes to RDATA on an acknowledge, or to IGNORE on a NACK.

Top module: `io_expander_i2c`

## Requirements
- R1: After reset, `pin_out` is all ones, `pin_oe` is all zeros (every pin is an input) and `sda_oe` is 0.
- R2: An address byte whose upper seven bits equal `{4'b0100, strap}` is acknowledged (SDA pulled low in the ninth clock). Any other address is not acknowledged, and the rest of that transfer is ignored.
- R3: Command 0x02 writes output half 0, which drives `pin_out[7:0]`, and 0x03 writes half 1, which drives `pin_out[15:8]`. A written byte reaches the pins only after its acknowledge clock has ended. During that acknowledge the pins still show the old value.
- R4: Successive data bytes of one write alternate between the selected register and its partner. The command byte's bit 0 picks the half and each byte flips that bit, with no limit on the number of bytes.
- R5: Commands 0x06 and 0x07 write the configuration halves. `pin_oe` is the inverse of configuration: 1 makes a pin an input, with its driver disabled.
- R6: A read made of a command write, a repeated START and the address with R/W=1 returns the selected register first, then its partner, alternating for every further byte. Bits go out MSB first.
- R7: Commands 0x04 and 0x05 write the polarity halves, which reset to zero. An input read returns the synchronised pin value XOR polarity.
- R8: Data written with input commands 0x00 and 0x01 is acknowledged but changes no register. Later reads of the input register return the pins.
- R9: When the controller does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START.
- R10: A STOP part-way through a write keeps every byte that was already acknowledged, and leaves the partner register unchanged.
- R11: Output and configuration registers read back the values that were last written to them.
- R12: The input value sent in a byte is the one present at that byte's load. A pin change during the transmission of a byte appears only in later bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Low three bits of the target address |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| pin_in | input | 16 | Pin levels as seen at the pads |
| pin_out | output | 16 | Output register value driven to the pins |
| pin_oe | output | 16 | Per-pin output enable, the inverse of configuration |

## Verification
The bench builds the block with its defaults: 8-bit halves and a two-flop synchroniser. The strap is tied to 101, and a second address that differs from it tests the mismatch case. An SCL phase of eight system clocks is long enough to cover the synchroniser and FSM latency. With it, the bench can check pin timing in the middle of an acknowledge, capture at byte load, alternation over three-byte transfers and release after a NACK.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;

    localparam logic [1:0] GRP_IN  = 2'd0;
    localparam logic [1:0] GRP_OUT = 2'd1;
    localparam logic [1:0] GRP_POL = 2'd2;
    localparam logic [1:0] GRP_CFG = 2'd3;

    localparam logic [3:0] ADDR_FIXED = 4'b0100;

endpackage

// File: rtl/gpx_line_sync.sv
module gpx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_sh;
    logic [DEPTH-1:0] sda_sh;
    logic scl_now, scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[DEPTH-2:0], scl_in};
            sda_sh <= {sda_sh[DEPTH-2:0], sda_in};
        end
    end

    always_comb begin
        scl_now   = scl_sh[STAGES-1];
        scl_prev  = scl_sh[STAGES];
        sda_q     = sda_sh[STAGES-1];
        sda_prev  = sda_sh[STAGES];
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_now & scl_prev & sda_prev & ~sda_q;
        stop_det  = scl_now & scl_prev & ~sda_prev & sda_q;
    end

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] pin_in,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [W-1:0]   wr_data,
    input  logic [2:0]     rd_sel,
    output logic [W-1:0]   rd_data,
    output logic [2*W-1:0] pin_out,
    output logic [2*W-1:0] pin_oe
);
    import gpx_pkg::*;

    localparam int HALVES = 2;

    logic [HALVES-1:0][W-1:0] out_r, pol_r, cfg_r;
    logic [HALVES-1:0][W-1:0] pin_m, pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_m <= '0;
            pin_s <= '0;
        end else begin
            pin_m <= pin_in;
            pin_s <= pin_m;
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_r[h] <= '1;
                pol_r[h] <= '0;
                cfg_r[h] <= '1;
            end else if (wr_en && (wr_sel[0] == 1'(h))) begin
                case (wr_sel[2:1])
                    GRP_OUT: out_r[h] <= wr_data;
                    GRP_POL: pol_r[h] <= wr_data;
                    GRP_CFG: cfg_r[h] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_sel[2:1])
            GRP_IN:  rd_data = pin_s[rd_sel[0]] ^ pol_r[rd_sel[0]];
            GRP_OUT: rd_data = out_r[rd_sel[0]];
            GRP_POL: rd_data = pol_r[rd_sel[0]];
            default: rd_data = cfg_r[rd_sel[0]];
        endcase
        pin_out = out_r;
        pin_oe  = ~cfg_r;
    end

endmodule

// File: rtl/gpx_target_fsm.sv
module gpx_target_fsm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sda_q,
    input  logic         scl_rise,
    input  logic         scl_fall,
    input  logic         start_det,
    input  logic         stop_det,
    input  logic [6:0]   dev_addr,
    input  logic [W-1:0] rd_data,
    output logic [2:0]   rd_sel,
    output logic         wr_en,
    output logic [2:0]   wr_sel,
    output logic [W-1:0] wr_data,
    output logic         sda_oe
);
    import gpx_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    tgt_state_t state, nxt;
    logic [CW-1:0] bitcnt;
    logic [W-1:0]  shreg;
    logic [2:0]    ptr;
    logic          rw;
    logic          mack;
    logic          addr_hit;

    assign addr_hit = (shreg[W-1 -: 7] == dev_addr);

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (scl_fall && bitcnt == FULL)
                                  nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw ? ST_RDATA : ST_CMD;
                ST_CMD:       if (scl_fall && bitcnt == FULL) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && bitcnt == FULL) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt == LAST) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = mack ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && bitcnt != FULL) begin
                        shreg  <= {shreg[W-2:0], sda_q};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == FULL) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) rw  <= shreg[0];
                        if (state == ST_CMD)  ptr <= shreg[2:0];
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw) begin
                        shreg  <= rd_data;
                        bitcnt <= '0;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) ptr <= ptr ^ 3'b001;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[W-2:0], 1'b0};
                        bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_q;
                    end else if (scl_fall && mack) begin
                        ptr   <= ptr ^ 3'b001;
                        shreg <= rd_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_sel  = (state == ST_RACK) ? (ptr ^ 3'b001) : ptr;
        wr_en   = (state == ST_WDATA_ACK) && scl_fall;
        wr_sel  = ptr;
        wr_data = shreg;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/io_expander_i2c.sv
module io_expander_i2c #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     strap,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic           sda_oe,
    input  logic [2*W-1:0] pin_in,
    output logic [2*W-1:0] pin_out,
    output logic [2*W-1:0] pin_oe
);
    import gpx_pkg::*;

    logic         sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [W-1:0] rd_data, wr_data;
    logic [2:0]   rd_sel, wr_sel;
    logic         wr_en;
    logic [6:0]   dev_addr;

    assign dev_addr = {ADDR_FIXED, strap};

    gpx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    gpx_target_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .rd_data   (rd_data),
        .rd_sel    (rd_sel),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    gpx_regfile #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

endmodule

// File: rtl/io_expander_i2c_chk.sv
module io_expander_i2c_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_in,
    input logic           sda_oe,
    input logic           wr_en,
    input logic [2:0]     wr_sel,
    input logic [2*W-1:0] pin_out,
    input logic [2*W-1:0] pin_oe
);

    AST_PINS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_out)); // R3

    AST_OE_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe)); // R5

    AST_INPUT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel[2:1] == 2'd0) |=> ($stable(pin_out) && $stable(pin_oe))); // R8

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in)) |-> $stable(sda_oe)); // R6

    AST_ONE_HALF_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($stable(pin_out[2*W-1:W]) || $stable(pin_out[W-1:0]))); // R4

endmodule

bind io_expander_i2c io_expander_i2c_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_in  (scl_in),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/test_io_expander_i2c.sv
module test_io_expander_i2c;

    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h4A;
    localparam logic [7:0] AR = 8'h4B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_low = 1'b0;
    logic [15:0] pin_in = 16'h0000;
    logic        sda_oe;
    logic [15:0] pin_out, pin_oe;
    logic        sda_line;
    logic [15:0] pins_at_ack;
    logic [7:0]  rbuf [4];
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    always #5 clk = ~clk;
    assign sda_line = !(sda_low || sda_oe);

    io_expander_i2c i_io_expander_i2c (
        .clk(clk), .rst_n(rst_n), .strap(3'b101),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_low = 1'b0; q(); scl_m = 1'b1; q();
        sda_low = 1'b1; q(); scl_m = 1'b0; q();
    endtask

    task automatic bstop();
        sda_low = 1'b1; q(); scl_m = 1'b1; q();
        sda_low = 1'b0; q(); q();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_low = !b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
        sda_low = 1'b0; q(); scl_m = 1'b1; q();
        ack = !sda_line;
        pins_at_ack = pin_out;
        q(); scl_m = 1'b0; q();
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
        end
        q(); sda_low = give_ack; q(); scl_m = 1'b1; q(); q();
        scl_m = 1'b0; q(); sda_low = 1'b0;
    endtask

    task automatic wr(input string req, input logic [7:0] cmd, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bstart();
        send(AW, a);  chk({req, " address ack"}, a, 1'b1);
        send(cmd, a); chk({req, " command ack"}, a, 1'b1);
        for (int k = 0; k < n; k++) begin
            send(d[k], a); chk({req, " data ack"}, a, 1'b1);
        end
        bstop();
    endtask

    task automatic rd(input logic [7:0] cmd, input int n);
        logic a;
        bstart(); send(AW, a); send(cmd, a);
        bstart(); send(AR, a);
        for (int k = 0; k < n; k++) recv(k != n - 1, rbuf[k]);
        bstop();
    endtask

    task automatic t_reset();
        chk("R1 pin_out", pin_out, 16'hFFFF);
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 sda_oe", sda_oe, 1'b0);
    endtask

    task automatic t_address();
        logic a;
        bstart(); send(8'h40, a); bstop();
        chk("R2 foreign address nack", a, 1'b0);
        bstart(); send(AW, a); bstop();
        chk("R2 own address ack", a, 1'b1);
    endtask

    task automatic t_write_out();
        logic a;
        bstart(); send(AW, a); send(8'h02, a);
        send(8'h3C, a);
        chk("R3 pins unchanged during ack", pins_at_ack, 16'hFFFF);
        send(8'hA5, a);
        chk("R3 half1 not yet on pins during ack", pins_at_ack, 16'hFF3C);
        bstop();
        chk("R3 output pair", pin_out, 16'hA53C);
    endtask

    task automatic t_toggle();
        wr("R4", 8'h03, 3, 8'h11, 8'h22, 8'h33);
        chk("R4 three-byte alternation", pin_out, 16'h3322);
    endtask

    task automatic t_config();
        wr("R5", 8'h06, 2, 8'h0F, 8'hF0, 8'h00);
        chk("R5 oe inverse of config", pin_oe, 16'h0FF0);
    endtask

    task automatic t_read();
        pin_in = 16'h5AC3; q();
        rd(8'h01, 3);
        chk("R6 first byte half1", rbuf[0], 8'h5A);
        chk("R6 second byte half0", rbuf[1], 8'hC3);
        chk("R6 third byte half1", rbuf[2], 8'h5A);
    endtask

    task automatic t_nack_release();
        logic a;
        logic [7:0] b;
        bstart(); send(AW, a); send(8'h00, a);
        bstart(); send(AR, a);
        recv(1'b0, b);
        chk("R9 released after nack", sda_oe, 1'b0);
        q(); q();
        chk("R9 still released", sda_line, 1'b1);
        bstop();
    endtask

    task automatic t_polarity();
        wr("R7", 8'h04, 2, 8'hFF, 8'h00, 8'h00);
        rd(8'h00, 2);
        chk("R7 inverted half0", rbuf[0], 8'h3C);
        chk("R7 plain half1", rbuf[1], 8'h5A);
        wr("R7", 8'h04, 1, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_input_ignored();
        wr("R8", 8'h00, 2, 8'h00, 8'h00, 8'h00);
        chk("R8 pin_out unchanged", pin_out, 16'h3322);
        chk("R8 pin_oe unchanged", pin_oe, 16'h0FF0);
        rd(8'h00, 2);
        chk("R8 input still pins half0", rbuf[0], 8'hC3);
        chk("R8 input still pins half1", rbuf[1], 8'h5A);
    endtask

    task automatic t_readback();
        rd(8'h02, 2);
        chk("R11 output half0", rbuf[0], 8'h22);
        chk("R11 output half1", rbuf[1], 8'h33);
        rd(8'h07, 2);
        chk("R11 config half1", rbuf[0], 8'hF0);
        chk("R11 config half0", rbuf[1], 8'h0F);
    endtask

    task automatic t_stop_mid();
        wr("R10", 8'h02, 1, 8'h99, 8'h00, 8'h00);
        chk("R10 acked byte kept, partner intact", pin_out, 16'h3399);
    endtask

    task automatic t_capture();
        logic a;
        logic [7:0] b;
        pin_in = 16'h00AA; q();
        bstart(); send(AW, a); send(8'h00, a);
        bstart(); send(AR, a);
        pin_in = 16'h0055;
        recv(1'b1, b); chk("R12 byte keeps value at load", b, 8'hAA);
        recv(1'b1, b); chk("R12 half1", b, 8'h00);
        recv(1'b0, b); chk("R12 new value in later byte", b, 8'h55);
        bstop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_address();
        t_write_out();
        t_toggle();
        t_config();
        t_read();
        t_nack_release();
        t_polarity();
        t_input_ignored();
        t_readback();
        t_stop_mid();
        t_capture();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule